// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading a two-level page table held in memory. The top ten bits of the virtual address pick an entry in the directory. The directory entry names the frame of a page table, the next ten bits pick an entry in that table, and the table entry names the 4 KB frame that the low twelve bits index into. The walk is one multi-cycle state machine that shares a single word-wide memory port between the two table fetches and any write-back of updated entries.

Each request carries a read/write flag and a user/supervisor flag. The walker checks that both entries are present and that the combined write and user permissions allow the access. On success it marks the entries it used as accessed, and marks the table entry dirty on a write. On a fault it reports a three-bit reason code, holds the faulting virtual address, and leaves memory untouched. When paging or protected mode is off, the address passes through unchanged and memory is not touched. Only one translation is in flight at a time.

States: `ST_IDLE` (waits for a request; moves to `ST_DIR_RD` when translating, or to `ST_DONE` on pass-through), `ST_DIR_RD` (fetches the directory entry; moves to `ST_TBL_RD`, or to `ST_DONE` on a not-present fault), `ST_TBL_RD` (fetches the table entry; moves to `ST_CHECK`, or to `ST_DONE` on a not-present fault), `ST_CHECK` (permission test; moves to `ST_DONE` on a fault, otherwise to `ST_DIR_WB`, `ST_TBL_WB` or `ST_DONE`, depending on which entries need updating), `ST_DIR_WB` (writes the directory entry back; moves to `ST_TBL_WB` or `ST_DONE`), `ST_TBL_WB` (writes the table entry back; moves to `ST_DONE`), and `ST_DONE` (one-cycle response; moves to `ST_IDLE`).

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read from address {root[31:12], va[31:22], 2'b00}. The table entry is read from {dir_entry[31:12], va[21:12], 2'b00}.
- R2: Bits 11:0 of the root base and of both entries never affect an address. Entry bits 3, 4 and 11:9 have no effect on the result and are kept unchanged by a write-back.
- R3: An entry with bit 0 (present) clear ends the walk with a fault whose code bit 0 is 0. A missing directory entry ends the walk after exactly one memory read.
- R4: A write faults (code bit 0 = 1) unless bit 1 (writable) is set in both the directory entry and the table entry.
- R5: A user access faults (code bit 0 = 1) unless bit 2 (user) is set in both entries.
- R6: On success the physical address is {table_entry[31:12], va[11:0]}, with no fault and a code of 0.
- R7: On success, each entry whose bit 5 (accessed) is clear is written back with bit 5 set. The directory entry is written first. An entry that needs no change is not written.
- R8: A successful write also sets bit 6 (dirty) in the table entry, so a clear dirty bit alone also causes a table write-back.
- R9: A faulting walk performs no memory write.
- R10: In the fault code, bit 1 is 1 for a write access and bit 2 is 1 for a user access.
- R11: The faulting virtual address output holds the virtual address of the last fault. It returns to 0 when the next request is accepted.
- R12: With paging off or protected mode off, the physical address equals the virtual address, there is no fault, and no memory access is made.
- R13: The request ready output is high only in the idle state, and it is low from acceptance until the response. The response valid output is a one-cycle pulse.
- R14: A memory request holds its address, direction and write data stable until the memory acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_root_base | input | 32 | Directory base (bits 31:12 used), sampled at acceptance |
| cfg_paging_on | input | 1 | Paging enable |
| cfg_prot_on | input | 1 | Protected-mode enable |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-mode access |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 1 | Translation faulted |
| rsp_code | output | 3 | Fault reason: bit0 present, bit1 write, bit2 user |
| fault_vaddr | output | 32 | Last faulting virtual address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | 32 | Word address (byte units) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory completes the access |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The bench builds the walker with the default 10/10/12 address split. It sweeps all 2048 combinations of directory present/write/user/accessed, table present/write/user/accessed/dirty, and access write/user. It varies the indices, the memory latency and the ignored entry bits at the same time. This puts every fault cause, every write-back pattern and the read/write address arithmetic within reach of an arithmetic model. Separate cases cover pass-through with paging off and with protected mode off.

// File: rtl/pt_pkg.sv
package pt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_TBL_RD,
        ST_CHECK,
        ST_DIR_WB,
        ST_TBL_WB,
        ST_DONE
    } walk_state_e;

    localparam int ENT_PRESENT  = 0;
    localparam int ENT_WRITABLE = 1;
    localparam int ENT_USER     = 2;
    localparam int ENT_ACCESSED = 5;
    localparam int ENT_DIRTY    = 6;

    localparam int CODE_W        = 3;
    localparam int CODE_PRESENT  = 0;
    localparam int CODE_WRITE    = 1;
    localparam int CODE_USER     = 2;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int VA_W      = 32,
    parameter int DIR_IDX_W = 10,
    parameter int TBL_IDX_W = 10,
    parameter int OFF_W     = 12
) (
    input  logic [VA_W-1:0] root_base,
    input  logic [VA_W-1:0] dir_entry,
    input  logic [VA_W-1:0] tbl_entry,
    input  logic [VA_W-1:0] vaddr,
    output logic [VA_W-1:0] dir_ent_addr,
    output logic [VA_W-1:0] tbl_ent_addr,
    output logic [VA_W-1:0] phys_addr
);
    localparam int FRAME_W   = VA_W - OFF_W;
    localparam int ENT_SHIFT = 2;

    logic [DIR_IDX_W-1:0] dir_idx;
    logic [TBL_IDX_W-1:0] tbl_idx;

    assign dir_idx = vaddr[VA_W-1 -: DIR_IDX_W];
    assign tbl_idx = vaddr[OFF_W +: TBL_IDX_W];

    assign dir_ent_addr = {root_base[VA_W-1 -: FRAME_W], {OFF_W{1'b0}}}
                        | (VA_W'(dir_idx) << ENT_SHIFT);
    assign tbl_ent_addr = {dir_entry[VA_W-1 -: FRAME_W], {OFF_W{1'b0}}}
                        | (VA_W'(tbl_idx) << ENT_SHIFT);
    assign phys_addr    = {tbl_entry[VA_W-1 -: FRAME_W], vaddr[OFF_W-1:0]};
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
    import pt_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0] dir_entry,
    input  logic [VA_W-1:0] tbl_entry,
    input  logic            is_write,
    input  logic            is_user,
    output logic            allowed
);
    logic eff_writable;
    logic eff_user;

    assign eff_writable = dir_entry[ENT_WRITABLE] & tbl_entry[ENT_WRITABLE];
    assign eff_user     = dir_entry[ENT_USER] & tbl_entry[ENT_USER];
    assign allowed      = !(is_write && !eff_writable) && !(is_user && !eff_user);
endmodule

// File: rtl/pt_entry_update.sv
module pt_entry_update
    import pt_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0] entry_in,
    input  logic            mark_dirty,
    output logic            need_wb,
    output logic [VA_W-1:0] entry_out
);
    always_comb begin
        entry_out = entry_in;
        entry_out[ENT_ACCESSED] = 1'b1;
        if (mark_dirty) begin
            entry_out[ENT_DIRTY] = 1'b1;
        end
        need_wb = (entry_out != entry_in);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int DIR_IDX_W = 10,
    parameter int TBL_IDX_W = 10,
    parameter int OFF_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   cfg_root_base,
    input  logic              cfg_paging_on,
    input  logic              cfg_prot_on,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic [CODE_W-1:0] rsp_code,
    output logic [VA_W-1:0]   fault_vaddr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [VA_W-1:0]   mem_addr,
    output logic [VA_W-1:0]   mem_wdata,
    input  logic              mem_ack,
    input  logic [VA_W-1:0]   mem_rdata
);
    localparam int NUM_LVL = 2;
    localparam int LVL_DIR = 0;
    localparam int LVL_TBL = 1;

    walk_state_e state_q, state_d;

    logic [VA_W-1:0] vaddr_q, root_q, dir_ent_q, tbl_ent_q;
    logic            wr_q, usr_q, pass_q, wr_seen_q;

    logic [VA_W-1:0] dir_ent_addr, tbl_ent_addr, phys_addr;
    logic            perm_ok;
    logic            accept;
    logic            bypass;

    logic [VA_W-1:0] lvl_entry [NUM_LVL];
    logic [VA_W-1:0] lvl_new   [NUM_LVL];
    logic            lvl_need  [NUM_LVL];
    logic            lvl_dirty [NUM_LVL];

    logic [CODE_W-1:0] np_code, pf_code;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign bypass = !(cfg_paging_on && cfg_prot_on);

    pt_addr_gen #(
        .VA_W(VA_W), .DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W), .OFF_W(OFF_W)
    ) u_addr (
        .root_base   (root_q),
        .dir_entry   (dir_ent_q),
        .tbl_entry   (tbl_ent_q),
        .vaddr       (vaddr_q),
        .dir_ent_addr(dir_ent_addr),
        .tbl_ent_addr(tbl_ent_addr),
        .phys_addr   (phys_addr)
    );

    pt_perm_check #(.VA_W(VA_W)) u_perm (
        .dir_entry(dir_ent_q),
        .tbl_entry(tbl_ent_q),
        .is_write (wr_q),
        .is_user  (usr_q),
        .allowed  (perm_ok)
    );

    assign lvl_entry[LVL_DIR] = dir_ent_q;
    assign lvl_entry[LVL_TBL] = tbl_ent_q;
    assign lvl_dirty[LVL_DIR] = 1'b0;
    assign lvl_dirty[LVL_TBL] = wr_q;

    for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
        pt_entry_update #(.VA_W(VA_W)) u_upd (
            .entry_in  (lvl_entry[lv]),
            .mark_dirty(lvl_dirty[lv]),
            .need_wb   (lvl_need[lv]),
            .entry_out (lvl_new[lv])
        );
    end

    always_comb begin
        np_code = '0;
        np_code[CODE_WRITE] = wr_q;
        np_code[CODE_USER]  = usr_q;
        pf_code = np_code;
        pf_code[CODE_PRESENT] = 1'b1;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = bypass ? ST_DONE : ST_DIR_RD;
                end
            end
            ST_DIR_RD: begin
                if (mem_ack) begin
                    state_d = mem_rdata[ENT_PRESENT] ? ST_TBL_RD : ST_DONE;
                end
            end
            ST_TBL_RD: begin
                if (mem_ack) begin
                    state_d = mem_rdata[ENT_PRESENT] ? ST_CHECK : ST_DONE;
                end
            end
            ST_CHECK: begin
                if (!perm_ok) begin
                    state_d = ST_DONE;
                end else if (lvl_need[LVL_DIR]) begin
                    state_d = ST_DIR_WB;
                end else if (lvl_need[LVL_TBL]) begin
                    state_d = ST_TBL_WB;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_DIR_WB: begin
                if (mem_ack) begin
                    state_d = lvl_need[LVL_TBL] ? ST_TBL_WB : ST_DONE;
                end
            end
            ST_TBL_WB: begin
                if (mem_ack) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_DIR_RD: begin
                mem_req  = 1'b1;
                mem_addr = dir_ent_addr;
            end
            ST_TBL_RD: begin
                mem_req  = 1'b1;
                mem_addr = tbl_ent_addr;
            end
            ST_CHECK:  ;
            ST_DIR_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_ent_addr;
                mem_wdata = lvl_new[LVL_DIR];
            end
            ST_TBL_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_ent_addr;
                mem_wdata = lvl_new[LVL_TBL];
            end
            ST_DONE:   rsp_valid = 1'b1;
            default:   ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q     <= '0;
            root_q      <= '0;
            dir_ent_q   <= '0;
            tbl_ent_q   <= '0;
            wr_q        <= 1'b0;
            usr_q       <= 1'b0;
            pass_q      <= 1'b0;
            wr_seen_q   <= 1'b0;
            rsp_paddr   <= '0;
            rsp_fault   <= 1'b0;
            rsp_code    <= '0;
            fault_vaddr <= '0;
        end else begin
            if (mem_req && mem_we && mem_ack) begin
                wr_seen_q <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        vaddr_q     <= req_vaddr;
                        root_q      <= cfg_root_base;
                        wr_q        <= req_write;
                        usr_q       <= req_user;
                        pass_q      <= bypass;
                        wr_seen_q   <= 1'b0;
                        fault_vaddr <= '0;
                        rsp_fault   <= 1'b0;
                        rsp_code    <= '0;
                        rsp_paddr   <= req_vaddr;
                    end
                end
                ST_DIR_RD: begin
                    if (mem_ack) begin
                        dir_ent_q <= mem_rdata;
                        if (!mem_rdata[ENT_PRESENT]) begin
                            rsp_fault   <= 1'b1;
                            rsp_code    <= np_code;
                            fault_vaddr <= vaddr_q;
                        end
                    end
                end
                ST_TBL_RD: begin
                    if (mem_ack) begin
                        tbl_ent_q <= mem_rdata;
                        if (!mem_rdata[ENT_PRESENT]) begin
                            rsp_fault   <= 1'b1;
                            rsp_code    <= np_code;
                            fault_vaddr <= vaddr_q;
                        end
                    end
                end
                ST_CHECK: begin
                    if (!perm_ok) begin
                        rsp_fault   <= 1'b1;
                        rsp_code    <= pf_code;
                        fault_vaddr <= vaddr_q;
                    end else begin
                        rsp_paddr <= phys_addr;
                    end
                end
                ST_DIR_WB, ST_TBL_WB, ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Assertions
    a_r13_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    a_r13_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready && !rsp_valid);
    a_r14_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));
    a_r7_wb_sets_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[ENT_ACCESSED]);
    a_r9_no_wb_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> !wr_seen_q);
    a_r12_pass_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        pass_q && !req_ready |-> !mem_req);
    a_r12_pass_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && pass_q |-> !rsp_fault && rsp_paddr == vaddr_q);
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 8192;
    localparam logic [31:0] ROOT_CFG = 32'h0000_1ABC;
    localparam logic [31:0] ROOT     = 32'h0000_1000;
    localparam logic [31:0] TBL_BASE = 32'h0000_3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_root_base = ROOT_CFG;
    logic        cfg_paging_on = 1'b1;
    logic        cfg_prot_on = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [2:0]  rsp_code;
    logic [31:0] fault_vaddr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata;

    logic [31:0] mem [MEM_WORDS];
    int          lat = 0;
    int          wcnt = 0;
    int          n_rd = 0;
    int          n_wr = 0;
    logic [31:0] rd_a0 = '0;
    logic [31:0] rd_a1 = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .cfg_root_base(cfg_root_base), .cfg_paging_on(cfg_paging_on), .cfg_prot_on(cfg_prot_on),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_code(rsp_code), .fault_vaddr(fault_vaddr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[14:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_ack && mem_req) begin
            if (mem_we) begin
                mem[mem_addr[14:2]] <= mem_wdata;
                n_wr <= n_wr + 1;
            end else begin
                n_rd  <= n_rd + 1;
                rd_a0 <= rd_a1;
                rd_a1 <= mem_addr;
            end
        end
        if (mem_req && !mem_ack) begin
            if (wcnt >= lat) begin
                mem_ack <= 1'b1;
                wcnt    <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic        got_fault;
    logic [31:0] got_paddr, got_fva;
    logic [2:0]  got_code;
    bit          busy_ok;
    bit          timed_out;

    task automatic run_req(input logic [31:0] va, input bit wr, input bit us);
        int guard;
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = 1'b1;
        guard = 0;
        timed_out = 1'b0;
        while (!rsp_valid) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            guard++;
            if (guard > 200) begin
                timed_out = 1'b1;
                break;
            end
        end
        got_fault = rsp_fault; got_paddr = rsp_paddr; got_code = rsp_code;
        got_fva = fault_vaddr;
        check(!timed_out, "R13 response arrives", 32'(guard), 32'd0);
        @(negedge clk);
        check(!rsp_valid && req_ready, "R13 one-cycle response pulse",
              {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0 &&
              fault_vaddr === '0, "R13 reset state",
              {28'd0, req_ready, rsp_valid, mem_req, |fault_vaddr}, 32'h8);
        rst_n = 1'b1;

        // R12: pass-through with paging off, then with protected mode off
        for (int k = 0; k < 4; k++) begin
            int r0, w0;
            logic [31:0] va;
            va = 32'hDEAD_B000 ^ (32'(k) * 32'h1357_9BDF);
            cfg_paging_on = (k >= 2);
            cfg_prot_on   = (k < 2);
            r0 = n_rd; w0 = n_wr;
            run_req(va, k[0], k[1]);
            check(got_paddr == va, "R12 pass-through address", got_paddr, va);
            check(!got_fault, "R12 pass-through no fault", {31'd0, got_fault}, 32'd0);
            check(n_rd == r0 && n_wr == w0, "R12 no memory access",
                  32'(n_rd - r0 + n_wr - w0), 32'd0);
        end
        cfg_paging_on = 1'b1;
        cfg_prot_on   = 1'b1;

        // Sweep over all attribute and access combinations
        for (int c = 0; c < 2048; c++) begin
            logic [9:0]  di, ti;
            logic [31:0] va, pde, pte, pde_a, pte_a, exp_pde, exp_pte, exp_pa, exp_fva;
            logic [31:0] junk;
            logic [2:0]  exp_code;
            bit          dp, tp, wr, us, perm, exp_fault, dwb, twb;
            int          r0, w0, exp_rd, exp_wr;
            di = 10'((c * 37) % 1024);
            ti = 10'((c * 101) % 1024);
            va = {di, ti, 12'((c * 293) % 4096)};
            junk = {20'd0, 3'(c % 8), 3'd0, 1'b0, 2'((c / 8) % 4), 3'd0} ;
            pde = TBL_BASE | junk | {27'd0, 1'b0, 1'b0, c[2:0] == 3'd0 ? 3'd0 : 3'd0};
            pde[0] = c[0]; pde[1] = c[1]; pde[2] = c[2]; pde[5] = c[3];
            pte = ({12'h0, 20'(c + 32'h12345)} << 12) | (junk ^ 32'h0000_0E18);
            pte[0] = c[4]; pte[1] = c[5]; pte[2] = c[6]; pte[5] = c[7]; pte[6] = c[8];
            wr = c[9]; us = c[10];
            lat = c % 3;
            pde_a = ROOT | (32'(di) << 2);
            pte_a = TBL_BASE | (32'(ti) << 2);
            mem[pde_a[14:2]] = pde;
            mem[pte_a[14:2]] = pte;

            dp = pde[0]; tp = pte[0];
            perm = !(wr && !(pde[1] && pte[1])) && !(us && !(pde[2] && pte[2]));
            exp_fault = !dp || !tp || !perm;
            exp_code  = exp_fault ? {us, wr, dp && tp} : 3'd0;
            exp_pa    = {pte[31:12], va[11:0]};
            exp_fva   = exp_fault ? va : 32'd0;
            dwb = !exp_fault && !pde[5];
            twb = !exp_fault && (!pte[5] || (wr && !pte[6]));
            exp_pde = dwb ? (pde | 32'h20) : pde;
            exp_pte = twb ? (pte | 32'h20 | (wr ? 32'h40 : 32'h0)) : pte;
            exp_rd  = dp ? 2 : 1;
            exp_wr  = int'(dwb) + int'(twb);

            r0 = n_rd; w0 = n_wr;
            run_req(va, wr, us);

            check(busy_ok, "R13 ready low while busy", {31'd0, busy_ok}, 32'd1);
            check(got_fault == exp_fault, "R3/R4/R5 fault flag",
                  {31'd0, got_fault}, {31'd0, exp_fault});
            check(got_code == exp_code, "R10 fault code", {29'd0, got_code}, {29'd0, exp_code});
            if (!exp_fault)
                check(got_paddr == exp_pa, "R6 physical address", got_paddr, exp_pa);
            check(got_fva == exp_fva, "R11 faulting address", got_fva, exp_fva);
            check(n_rd - r0 == exp_rd, "R3 R14 memory read count",
                  32'(n_rd - r0), 32'(exp_rd));
            if (dp)
                check(rd_a0 == pde_a && rd_a1 == pte_a, "R1 R2 entry addresses",
                      rd_a1, pte_a);
            else
                check(rd_a1 == pde_a, "R1 R2 directory address", rd_a1, pde_a);
            check(n_wr - w0 == exp_wr, "R7 R9 write-back count",
                  32'(n_wr - w0), 32'(exp_wr));
            check(mem[pde_a[14:2]] == exp_pde, "R7 R2 directory entry after walk",
                  mem[pde_a[14:2]], exp_pde);
            check(mem[pte_a[14:2]] == exp_pte, "R8 R9 table entry after walk",
                  mem[pte_a[14:2]], exp_pte);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule